// File: doc/BRIEF.md
# Guarded Storage and Backplane Control Registers

This block is a byte-wide register bank on a simple synchronous host bus (address, write data, write strobe, read strobe, registered read data). It owns the control pins for a storage device (a hardware erase line and a cache-flush line) and the open-drain enables for two backplane signals: a maskable reset line and a write-protect override line. It also turns falling edges on the incoming maskable-reset line into a board reset request, and it holds a scratchpad byte that software can use to prove bus access.

The erase line is guarded. It fires only after bit 0 of the erase register receives a 1, then a 0, then a 1 on three consecutive writes to that register. It then stays asserted for a fixed, parameterised number of clocks. Reading the erase register shows the live pin state. The write-protect override can only be switched on while a strap input says this board is the backplane system controller.

All outputs are registered. The strap and the incoming reset line are brought into the clock domain by two-flop synchronisers.

Top module: `guard_ctl_regs`

## Requirements
- R1: Read data is registered. One cycle after a read strobe, `bus_rdata` holds the addressed register (erase 0x6BF, flush 0x6C0, backplane 0x6C1, scratchpad 0x6C6). Any other address reads 0x00, and a cycle with no read strobe leaves 0x00.
- R2: After reset, the erase pin is negated and its register reads 0x01. The flush register reads 0x00, so the flush pin is asserted. The backplane register reads 0x00, with no open-drain enable and no reset pulse. The scratchpad reads 0xFF.
- R3: When bit 0 of the erase register receives 1, 0, 1 on three consecutive writes to it, `erase_act_o` goes high in the cycle after the third write.
- R4: A write to any other address between the erase-sequence writes restarts the sequence. So does a bit-0 value that breaks the pattern. A breaking write whose bit 0 is 1 counts as the first step of a new sequence.
- R5: Once fired, `erase_act_o` stays high for exactly ERASE_CYCLES clocks and then returns low.
- R6: The erase register reads bit 0 = 0 while the pin is asserted and 1 while it is negated, with bits 7:1 = 0. Writes that do not complete the sequence leave this readback unchanged.
- R7: Writing the flush register with bit 0 = 0 asserts `flush_act_o` in the next cycle, and bit 0 = 1 negates it, with no unlock step. Bit 0 reads 0 while the pin is asserted. Bits 7:1 read 0.
- R8: In the backplane register, bit 4 (reset mask) and bit 3 (drive the maskable-reset line low, reflected on `mrst_oe_o`) are written directly and read back. Bits 7:5 and 1:0 read 0.
- R9: Bit 2 of the backplane register (write-protect override, reflected on `wp_oe_o`) takes the written value while the synchronised `syscon_n_i` is low. While it is high, a write of 1 to bit 2 leaves the bit unchanged and a write of 0 clears it.
- R10: With the mask bit at 1, each falling edge of `mrst_n_i` gives exactly one single-cycle `board_rst_o` pulse, three clocks after the input is first sampled low. With the mask bit at 0, no pulse occurs.
- R11: The scratchpad stores and returns any byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| syscon_n_i | input | 1 | Strap, low when this board is system controller (asynchronous) |
| mrst_n_i | input | 1 | Incoming backplane maskable reset, active low (asynchronous) |
| erase_act_o | output | 1 | Storage erase pin asserted |
| flush_act_o | output | 1 | Storage cache-flush pin asserted |
| mrst_oe_o | output | 1 | Open-drain enable pulling the maskable-reset line low |
| wp_oe_o | output | 1 | Open-drain enable pulling the write-protect override line low |
| board_rst_o | output | 1 | Single-cycle board reset request |

## Verification
The bench goes after the unlock tracker's edge cases. These are a pattern broken by a repeated 0, a pattern broken by a repeated 1 that must count as a fresh start, and a write to the scratchpad slipped between steps. A tracker that ignores foreign writes or resets to idle on a stray 1 would fire when it should not, or fail to fire when it should. The bench measures the erase pulse to the exact clock, catching an off-by-one timer, and reads the erase register mid-pulse to catch a design that returns stored write data instead of the pin. It drives the strap both ways around write-protect writes, where a missing guard or a guard that clears on an ignored write shows on `wp_oe_o`. It holds the reset line low for many clocks, where a level-sensitive detector would emit a train of pulses instead of one.

// File: rtl/guard_ctl_pkg.sv
package guard_ctl_pkg;
  localparam int unsigned DATA_W = 8;

  // progress through the 1-0-1 unlock pattern
  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_ONE      = 2'd1,
    SEQ_ONE_ZERO = 2'd2
  } seq_e;
endpackage

// File: rtl/gc_sync.sv
module gc_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/erase_unlock.sv
module erase_unlock
  import guard_ctl_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 16,
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,    // write to the erase register
  input  logic wr_other,  // write to any other address
  input  logic wr_bit,    // bit 0 of that write
  output logic active_o
);
  seq_e             seq_q;
  logic [CNT_W-1:0] left_q;
  logic             fire;

  assign fire = wr_hit && wr_bit && (seq_q == SEQ_ONE_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= SEQ_IDLE;
    end else if (wr_other) begin
      seq_q <= SEQ_IDLE;
    end else if (wr_hit) begin
      case (seq_q)
        SEQ_IDLE:     seq_q <= wr_bit ? SEQ_ONE : SEQ_IDLE;
        SEQ_ONE:      seq_q <= wr_bit ? SEQ_ONE : SEQ_ONE_ZERO;
        SEQ_ONE_ZERO: seq_q <= SEQ_IDLE;
        default:      seq_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      left_q   <= '0;
    end else if (fire) begin
      active_o <= 1'b1;
      left_q   <= CNT_W'(PULSE_CYC - 1);
    end else if (left_q != '0) begin
      left_q   <= left_q - 1'b1;
    end else begin
      active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/guard_ctl_regs.sv
module guard_ctl_regs
  import guard_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] ADDR_ERASE = 'h6BF,
  parameter logic [ADDR_W-1:0] ADDR_FLUSH = 'h6C0,
  parameter logic [ADDR_W-1:0] ADDR_BPLN  = 'h6C1,
  parameter logic [ADDR_W-1:0] ADDR_SCR   = 'h6C6,
  parameter int unsigned ERASE_CYCLES = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] SCR_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              syscon_n_i,
  input  logic              mrst_n_i,
  output logic              erase_act_o,
  output logic              flush_act_o,
  output logic              mrst_oe_o,
  output logic              wp_oe_o,
  output logic              board_rst_o
);
  localparam int unsigned BIT_MASK = 4;
  localparam int unsigned BIT_MDRV = 3;
  localparam int unsigned BIT_WP   = 2;

  logic              wr_erase, wr_other;
  logic              bp_mask_q;
  logic [DATA_W-1:0] scr_q;
  logic [1:0]        sync_q;
  logic              mrst_s, strap_s, mrst_prev_q;
  logic [DATA_W-1:0] rd_val;

  assign wr_erase = bus_we && (bus_addr == ADDR_ERASE);
  assign wr_other = bus_we && (bus_addr != ADDR_ERASE);

  gc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({syscon_n_i, mrst_n_i}), .q(sync_q)
  );
  assign mrst_s  = sync_q[0];
  assign strap_s = sync_q[1];

  erase_unlock #(.PULSE_CYC(ERASE_CYCLES)) u_unlock (
    .clk(clk), .rst(rst), .wr_hit(wr_erase), .wr_other(wr_other),
    .wr_bit(bus_wdata[0]), .active_o(erase_act_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_act_o <= 1'b1;
      bp_mask_q   <= 1'b0;
      mrst_oe_o   <= 1'b0;
      wp_oe_o     <= 1'b0;
      scr_q       <= SCR_RST;
    end else if (bus_we) begin
      if (bus_addr == ADDR_FLUSH) flush_act_o <= ~bus_wdata[0];
      if (bus_addr == ADDR_BPLN) begin
        bp_mask_q <= bus_wdata[BIT_MASK];
        mrst_oe_o <= bus_wdata[BIT_MDRV];
        wp_oe_o   <= strap_s ? (wp_oe_o & bus_wdata[BIT_WP]) : bus_wdata[BIT_WP];
      end
      if (bus_addr == ADDR_SCR) scr_q <= bus_wdata;
    end
  end

  // falling edge of the synchronised backplane reset, gated by the mask
  always_ff @(posedge clk) begin
    if (rst) begin
      mrst_prev_q <= 1'b1;
      board_rst_o <= 1'b0;
    end else begin
      mrst_prev_q <= mrst_s;
      board_rst_o <= bp_mask_q & mrst_prev_q & ~mrst_s;
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      ADDR_ERASE: rd_val[0] = ~erase_act_o;
      ADDR_FLUSH: rd_val[0] = ~flush_act_o;
      ADDR_BPLN: begin
        rd_val[BIT_MASK] = bp_mask_q;
        rd_val[BIT_MDRV] = mrst_oe_o;
        rd_val[BIT_WP]   = wp_oe_o;
      end
      ADDR_SCR:   rd_val = scr_q;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_re ? rd_val : '0;
  end
endmodule

// File: rtl/guard_ctl_regs_chk.sv
module guard_ctl_regs_chk #(
  parameter int unsigned ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] ADDR_ERASE = 'h6BF,
  parameter logic [ADDR_W-1:0] ADDR_FLUSH = 'h6C0,
  parameter int unsigned ERASE_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd0,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_rdata,
  input logic              syscon_n_i,
  input logic              erase_act_o,
  input logic              flush_act_o,
  input logic              wp_oe_o,
  input logic              board_rst_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= erase_act_o ? run_q + 1 : '0;
  end

  p_idle_rdata_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_re) |-> bus_rdata == 8'h00);

  p_erase_fire_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_act_o) |-> ($past(bus_we) && $past(bus_addr) == ADDR_ERASE && $past(wd0)));

  p_erase_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(erase_act_o) |-> run_q == ERASE_CYCLES);

  p_erase_max_r5: assert property (@(posedge clk) disable iff (rst)
    run_q <= ERASE_CYCLES);

  p_flush_direct_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_we) && $past(bus_addr) == ADDR_FLUSH) |-> flush_act_o == !$past(wd0));

  p_wp_guard_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(wp_oe_o) |-> $past(syscon_n_i, 3) == 1'b0);

  p_rst_single_r10: assert property (@(posedge clk) disable iff (rst)
    board_rst_o |=> !board_rst_o);
endmodule

bind guard_ctl_regs guard_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .ADDR_ERASE(ADDR_ERASE), .ADDR_FLUSH(ADDR_FLUSH),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .wd0(bus_wdata[0]),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .syscon_n_i(syscon_n_i), .erase_act_o(erase_act_o),
  .flush_act_o(flush_act_o), .wp_oe_o(wp_oe_o), .board_rst_o(board_rst_o)
);

// File: tb/guard_ctl_regs_bench.sv
module guard_ctl_regs_bench;
  localparam int ERASE_N = 16;
  localparam logic [11:0] A_ER = 12'h6BF, A_FL = 12'h6C0, A_BP = 12'h6C1, A_SC = 12'h6C6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic syscon_n_i = 1'b1, mrst_n_i = 1'b1;
  logic erase_act_o, flush_act_o, mrst_oe_o, wp_oe_o, board_rst_o;

  always #10 clk = ~clk;

  guard_ctl_regs #(.ADDR_W(12), .ERASE_CYCLES(ERASE_N)) u_guard_ctl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .syscon_n_i(syscon_n_i), .mrst_n_i(mrst_n_i),
    .erase_act_o(erase_act_o), .flush_act_o(flush_act_o),
    .mrst_oe_o(mrst_oe_o), .wp_oe_o(wp_oe_o), .board_rst_o(board_rst_o)
  );

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_step, m_rem;
  bit   m_flush, m_mask, m_mdrv, m_wp, m_pulse, m_valid;
  logic [7:0] m_scr, m_rdata;
  bit   mrst_q[$];
  bit   strap_q[$];

  function automatic logic [7:0] m_read(input logic [11:0] a);
    case (a)
      A_ER:    return {7'd0, m_rem == 0};
      A_FL:    return {7'd0, !m_flush};
      A_BP:    return {3'd0, m_mask, m_mdrv, m_wp, 2'd0};
      A_SC:    return m_scr;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_rem = 0; m_flush = 1; m_mask = 0; m_mdrv = 0; m_wp = 0;
      m_pulse = 0; m_scr = 8'hFF; m_rdata = 0;
      mrst_q = '{1, 1, 1};
      strap_q = '{1, 1, 1};
      m_valid = 1;
    end else begin
      bit fire;
      bit b;
      m_rdata = bus_re ? m_read(bus_addr) : 8'h00;
      m_pulse = m_mask && mrst_q[0] && !mrst_q[1];
      b = bus_wdata[0];
      fire = bus_we && bus_addr == A_ER && b && m_step == 2;
      if (bus_we) begin
        if (bus_addr == A_ER) begin
          if (m_step == 0)      m_step = b ? 1 : 0;
          else if (m_step == 1) m_step = b ? 1 : 2;
          else                  m_step = 0;
        end else begin
          m_step = 0;
        end
        if (bus_addr == A_FL) m_flush = !b;
        if (bus_addr == A_BP) begin
          m_mask = bus_wdata[4];
          m_mdrv = bus_wdata[3];
          if (!strap_q[1]) m_wp = bus_wdata[2];
          else             m_wp = m_wp && bus_wdata[2];
        end
        if (bus_addr == A_SC) m_scr = bus_wdata;
      end
      if (fire)          m_rem = ERASE_N;
      else if (m_rem > 0) m_rem = m_rem - 1;
      void'(mrst_q.pop_front());  mrst_q.push_back(mrst_n_i);
      void'(strap_q.pop_front()); strap_q.push_back(syscon_n_i);
    end
  end

  always @(negedge clk) begin
    if (m_valid) begin
      chk("R1 rdata vs model",   bus_rdata,   m_rdata);
      chk("R3 erase vs model",   {7'd0, erase_act_o}, {7'd0, m_rem > 0});
      chk("R7 flush vs model",   {7'd0, flush_act_o}, {7'd0, m_flush});
      chk("R8 mrst_oe vs model", {7'd0, mrst_oe_o},   {7'd0, m_mdrv});
      chk("R9 wp_oe vs model",   {7'd0, wp_oe_o},     {7'd0, m_wp});
      chk("R10 rst vs model",    {7'd0, board_rst_o}, {7'd0, m_pulse});
    end
    if (!rst && board_rst_o) pulses++;
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R2 reset state
    chk("R2 erase pin", {7'd0, erase_act_o}, 8'h00);
    chk("R2 flush pin", {7'd0, flush_act_o}, 8'h01);
    chk("R2 drives",    {6'd0, mrst_oe_o, wp_oe_o}, 8'h00);
    chk("R2 rst pulse", {7'd0, board_rst_o}, 8'h00);
    rd(A_ER, 8'h01, "R2 erase reg");
    rd(A_FL, 8'h00, "R2 flush reg");
    rd(A_BP, 8'h00, "R2 bpln reg");
    rd(A_SC, 8'hFF, "R2 scratch reg");
    rd(12'h123, 8'h00, "R1 unmapped");
    // R11 scratchpad
    wr(A_SC, 8'hA5); rd(A_SC, 8'hA5, "R11 scratch A5");
    wr(A_SC, 8'h3C); rd(A_SC, 8'h3C, "R11 scratch 3C");
    // R7 flush
    wr(A_FL, 8'hFF); chk("R7 flush negated", {7'd0, flush_act_o}, 8'h00);
    rd(A_FL, 8'h01, "R7 flush read");
    wr(A_FL, 8'h00); chk("R7 flush asserted", {7'd0, flush_act_o}, 8'h01);
    rd(A_FL, 8'h00, "R7 flush read 0");
    // R3 / R5 unlock and pulse length
    wr(A_ER, 8'h01); wr(A_ER, 8'h00); wr(A_ER, 8'h01);
    chk("R3 erase fires", {7'd0, erase_act_o}, 8'h01);
    begin
      int n = 0;
      while (erase_act_o && n < 1000) begin n++; @(negedge clk); end
      chk("R5 erase length", 8'(n), 8'(ERASE_N));
    end
    rd(A_ER, 8'h01, "R6 erase read after pulse");
    // R6 live readback
    wr(A_ER, 8'h01); wr(A_ER, 8'h00); wr(A_ER, 8'hFF);
    rd(A_ER, 8'h00, "R6 erase read while active");
    idle(ERASE_N + 4);
    // R4 repeated zero breaks
    wr(A_ER, 8'h01); wr(A_ER, 8'h00); wr(A_ER, 8'h00); wr(A_ER, 8'h01);
    chk("R4 broken by 0", {7'd0, erase_act_o}, 8'h00);
    wr(A_ER, 8'h00); wr(A_ER, 8'h01);
    chk("R4 trailing 1 restarts", {7'd0, erase_act_o}, 8'h01);
    idle(ERASE_N + 4);
    // R4 foreign write breaks
    wr(A_ER, 8'h01); wr(A_ER, 8'h00); wr(A_SC, 8'h00); wr(A_ER, 8'h01);
    chk("R4 foreign write", {7'd0, erase_act_o}, 8'h00);
    wr(A_ER, 8'h00); wr(A_ER, 8'h01);
    chk("R4 fire after restart", {7'd0, erase_act_o}, 8'h01);
    idle(ERASE_N + 4);
    // R4 repeated one counts as a first step
    wr(A_ER, 8'h01); wr(A_ER, 8'h01); wr(A_ER, 8'h00); wr(A_ER, 8'h01);
    chk("R4 1101 fires", {7'd0, erase_act_o}, 8'h01);
    idle(ERASE_N + 4);
    // R6 writes without sequence do not change readback
    wr(A_ER, 8'h00); rd(A_ER, 8'h01, "R6 write 00 ignored");
    wr(A_ER, 8'hFE); rd(A_ER, 8'h01, "R6 write FE ignored");
    // R8 backplane bits, strap high
    wr(A_BP, 8'hFF);
    chk("R8 mrst drive", {7'd0, mrst_oe_o}, 8'h01);
    chk("R9 wp blocked", {7'd0, wp_oe_o}, 8'h00);
    rd(A_BP, 8'h18, "R8 bpln read FF");
    wr(A_BP, 8'h00); rd(A_BP, 8'h00, "R8 bpln cleared");
    // R9 guard
    syscon_n_i = 0; idle(4);
    wr(A_BP, 8'h04);
    chk("R9 wp set as syscon", {7'd0, wp_oe_o}, 8'h01);
    rd(A_BP, 8'h04, "R9 bpln read 04");
    syscon_n_i = 1; idle(4);
    wr(A_BP, 8'h04); chk("R9 wp held", {7'd0, wp_oe_o}, 8'h01);
    wr(A_BP, 8'h00); chk("R9 wp cleared", {7'd0, wp_oe_o}, 8'h00);
    wr(A_BP, 8'h04); chk("R9 wp not set", {7'd0, wp_oe_o}, 8'h00);
    // R10 reset request
    wr(A_BP, 8'h10);
    pulses = 0;
    mrst_n_i = 0; idle(10);
    chk("R10 one pulse", 8'(pulses), 8'd1);
    mrst_n_i = 1; idle(4);
    wr(A_BP, 8'h00);
    mrst_n_i = 0; idle(10);
    chk("R10 masked", 8'(pulses), 8'd1);
    mrst_n_i = 1; idle(4);
    wr(A_BP, 8'h10);
    @(negedge clk); mrst_n_i = 0; @(negedge clk); mrst_n_i = 1;
    idle(8);
    chk("R10 short low", 8'(pulses), 8'd2);
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule